// File: doc/BRIEF.md
# Halt-Depth Power Sequencer

This block sequences the low-power states of a small processor core. When the CPU executes its halt instruction it raises a one-cycle strobe. At that moment the block reads the wake-up timer configuration. It then parks the core either in a full halt, where every clock enable is dropped, or in an active halt, where the main oscillator and one wake-up timer keep running so that they can provide a time base. It also clears the core's global interrupt mask on entry, so an interrupt that is already pending brings the core straight back.

On the way out the block separates two cases. An interrupt wake resumes the CPU in the next cycle and reports which source caused it. A reset wake holds the core in a start-up state for 256 or 512 cycles, then asks for a reset-vector fetch. The block also handles the watchdog. If the watchdog is running and its halt-reset option is set, the halt instruction produces a watchdog reset request instead of a halt. If that option is clear, the halt goes ahead and the watchdog keeps bounding the stay.

Top module: `halt_ctrl`

## Requirements
- R1: A `halt_strobe` accepted in RUN selects active halt (`pstate` = 4'b0100) when `lt_tb_ie` is 1, or when `at_ovf_ie` is 1 and `at_clk_sel` is 2'b01. Every other combination selects full halt (`pstate` = 4'b0010). The new state is visible one cycle after the strobe. RUN is 4'b0001 and the start-up state is 4'b1000.
- R2: Every accepted halt strobe produces a one-cycle `imask_clr` pulse in the cycle after the strobe.
- R3: If the wake source for the chosen depth is already asserted with the strobe, the state stays RUN. `imask_clr` and `irq_resume` then pulse together in the next cycle. The wake source is the selected timer interrupt for active halt and `ext_irq` for full halt.
- R4: In RUN all five clock enables are 1. In active halt only `osc_en` and the selected timer's enable are 1; the timer is the lite timer when `lt_tb_ie` was 1 at entry and the auto-reload timer otherwise. In full halt all enables are 0. In the start-up state only `osc_en` is 1.
- R5: Active halt ignores `ext_irq` and the unselected timer's interrupt, and leaves only on the selected timer interrupt or `rst_wake`.
- R6: An interrupt wake returns to RUN in the next cycle with a one-cycle `irq_resume` pulse. `wake_vec` shows the source during that pulse: 0 external, 1 lite timer, 2 auto-reload timer. At all other times `wake_vec` is 0.
- R7: Full halt ignores both timer interrupts and leaves only on `ext_irq` or `rst_wake`.
- R8: `rst_wake` enters the start-up state. The state lasts 256 cycles when `boot_long` is 0 and 512 cycles when it is 1, with `boot_long` sampled together with `rst_wake`. The state then returns to RUN with a one-cycle `rst_fetch` pulse.
- R9: `rst_wake` takes priority over a timer interrupt, `ext_irq` or `halt_strobe` arriving in the same cycle. A `rst_wake` during the start-up state restarts the delay.
- R10: A halt strobe with `wdg_active` and `wdg_halt_rst` both 1 produces a one-cycle `wdg_rst_req` and no halt and no `imask_clr`. With `wdg_halt_rst` at 0 there is no request and the halt proceeds.
- R11: While `rst_n` is low at a clock edge the block returns to RUN with all pulses at 0.
- R12: A `halt_strobe` outside RUN has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| halt_strobe | input | 1 | One-cycle pulse: CPU executed the halt instruction |
| lt_tb_ie | input | 1 | Lite timer time-base interrupt enable |
| at_ovf_ie | input | 1 | Auto-reload timer overflow interrupt enable |
| at_clk_sel | input | 2 | Auto-reload timer clock selection (2'b01 qualifies) |
| wdg_active | input | 1 | Watchdog is running |
| wdg_halt_rst | input | 1 | Watchdog resets on halt instruction |
| lt_irq | input | 1 | Lite timer interrupt |
| at_irq | input | 1 | Auto-reload timer interrupt |
| ext_irq | input | 1 | Any other interrupt |
| rst_wake | input | 1 | Reset wake event |
| boot_long | input | 1 | Start-up delay select: 0 = 256, 1 = 512 cycles |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| lt_clk_en | output | 1 | Lite timer clock enable |
| at_clk_en | output | 1 | Auto-reload timer clock enable |
| imask_clr | output | 1 | Pulse: clear the global interrupt mask |
| irq_resume | output | 1 | Pulse: resume CPU and service the wake interrupt |
| wake_vec | output | 2 | Wake source code during `irq_resume` |
| rst_fetch | output | 1 | Pulse: fetch the reset vector |
| wdg_rst_req | output | 1 | Pulse: watchdog reset instead of halt |
| pstate | output | 4 | One-hot power state |

## Verification
The halt decision is tried with the time-base enable alone, with the overflow enable under a qualifying and a non-qualifying clock selection, and with a wake source already high at the strobe. These runs separate active halt from full halt and from the instant-wake path. Each halt depth then receives its own wake source and also the sources it has to ignore, which shows that wake filtering depends on the depth chosen. Reset wakes are sent under both delay selections and together with a competing timer interrupt, so the start-up length and the priority are measured separately. The watchdog option is tried in both settings.

// File: rtl/halt_ctrl_pkg.sv
// Shared types for the halt sequencer: one-hot power states and wake codes.
package halt_ctrl_pkg;
    typedef enum logic [3:0] {
        PS_RUN   = 4'b0001,
        PS_HALT  = 4'b0010,
        PS_AHALT = 4'b0100,
        PS_BOOT  = 4'b1000
    } pstate_t;

    localparam logic [1:0] WV_EXT = 2'd0;
    localparam logic [1:0] WV_LT  = 2'd1;
    localparam logic [1:0] WV_AT  = 2'd2;
endpackage

// File: rtl/halt_depth_dec.sv
// Decides the halt depth from the timer configuration and reports whether
// the matching wake source is already pending. Purely combinational;
// assumes inputs are stable around the halt strobe.
module halt_depth_dec
    import halt_ctrl_pkg::*;
#(
    parameter logic [1:0] QUAL_SEL = 2'b01
) (
    input  logic       tb_ie,
    input  logic       ovf_ie,
    input  logic [1:0] clk_sel,
    input  logic       lt_irq,
    input  logic       at_irq,
    input  logic       ext_irq,
    output logic       active_sel,
    output logic       lite_sel,
    output logic       pend_wake,
    output logic [1:0] pend_vec
);
    // Depth choice and pending-wake detection.
    always_comb begin
        active_sel = tb_ie || (ovf_ie && (clk_sel == QUAL_SEL));
        lite_sel   = tb_ie;
        if (active_sel) begin
            pend_wake = lite_sel ? lt_irq : at_irq;
            pend_vec  = lite_sel ? WV_LT : WV_AT;
        end else begin
            pend_wake = ext_irq;
            pend_vec  = WV_EXT;
        end
    end
endmodule

// File: rtl/boot_delay_ctr.sv
// Down-counter timing the start-up delay after a reset wake. Loaded with
// the selected length minus one; counts only while the sequencer is in the
// start-up state; done when it reaches zero.
module boot_delay_ctr #(
    parameter int SHORT_CYC = 256,
    parameter int LONG_CYC  = 512,
    localparam int CNT_W    = $clog2(LONG_CYC) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    input  logic in_boot,
    output logic done
);
    localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Load on a reset wake, otherwise count down inside the start-up state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= long_sel ? LD_LONG : LD_SHORT;
        end else if (in_boot && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LD_LONG);
    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && in_boot && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/halt_fsm.sv
// Power-state machine: accepts the halt strobe, handles the watchdog
// option, filters wake sources by depth and issues the exit pulses.
// Assumes rst_wake and interrupts are synchronous to clk.
module halt_fsm
    import halt_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_strobe,
    input  logic       wdg_active,
    input  logic       wdg_halt_rst,
    input  logic       lt_irq,
    input  logic       at_irq,
    input  logic       ext_irq,
    input  logic       rst_wake,
    input  logic       active_sel,
    input  logic       lite_sel,
    input  logic       pend_wake,
    input  logic [1:0] pend_vec,
    input  logic       boot_done,
    output pstate_t    state,
    output logic       lite_q,
    output logic       imask_clr,
    output logic       irq_resume,
    output logic [1:0] wake_vec,
    output logic       rst_fetch,
    output logic       wdg_rst_req
);
    // Next state and registered one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PS_RUN;
            lite_q      <= 1'b1;
            imask_clr   <= 1'b0;
            irq_resume  <= 1'b0;
            wake_vec    <= WV_EXT;
            rst_fetch   <= 1'b0;
            wdg_rst_req <= 1'b0;
        end else begin
            imask_clr   <= 1'b0;
            irq_resume  <= 1'b0;
            wake_vec    <= WV_EXT;
            rst_fetch   <= 1'b0;
            wdg_rst_req <= 1'b0;
            if (rst_wake) begin
                state <= PS_BOOT;
            end else begin
                unique case (state)
                    PS_RUN: begin
                        if (halt_strobe) begin
                            if (wdg_active && wdg_halt_rst) begin
                                wdg_rst_req <= 1'b1;
                            end else begin
                                imask_clr <= 1'b1;
                                if (pend_wake) begin
                                    irq_resume <= 1'b1;
                                    wake_vec   <= pend_vec;
                                end else begin
                                    state  <= active_sel ? PS_AHALT : PS_HALT;
                                    lite_q <= lite_sel;
                                end
                            end
                        end
                    end
                    PS_HALT: begin
                        if (ext_irq) begin
                            state      <= PS_RUN;
                            irq_resume <= 1'b1;
                            wake_vec   <= WV_EXT;
                        end
                    end
                    PS_AHALT: begin
                        if (lite_q ? lt_irq : at_irq) begin
                            state      <= PS_RUN;
                            irq_resume <= 1'b1;
                            wake_vec   <= lite_q ? WV_LT : WV_AT;
                        end
                    end
                    PS_BOOT: begin
                        if (boot_done) begin
                            state     <= PS_RUN;
                            rst_fetch <= 1'b1;
                        end
                    end
                    default: state <= PS_RUN;
                endcase
            end
        end
    end

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);
    assert_entry_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_RUN && (state == PS_HALT || state == PS_AHALT)) |-> imask_clr);
    assert_resume_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_resume |-> (state == PS_RUN));
    assert_fetch_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fetch |-> (state == PS_RUN && $past(state) == PS_BOOT));
    assert_wdg_no_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst_req |-> (state == PS_RUN && !imask_clr));
    assert_rst_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wake |=> (state == PS_BOOT));
endmodule

// File: rtl/clk_en_map.sv
// Maps the power state to the clock enables. Timer enables are generated
// per timer: index 0 is the lite timer, index 1 the auto-reload timer.
module clk_en_map
    import halt_ctrl_pkg::*;
#(
    parameter int N_TMR = 2
) (
    input  pstate_t          state,
    input  logic             lite_q,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic [N_TMR-1:0] tmr_clk_en
);
    // Core and oscillator enables per state.
    always_comb begin
        osc_en        = (state != PS_HALT);
        cpu_clk_en    = (state == PS_RUN);
        periph_clk_en = (state == PS_RUN);
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic chosen;
        // Timer i keeps its clock in active halt only if it is the wake timer.
        always_comb begin
            chosen        = (i == 0) ? lite_q : !lite_q;
            tmr_clk_en[i] = (state == PS_RUN) || ((state == PS_AHALT) && chosen);
        end
    end
endmodule

// File: rtl/halt_ctrl.sv
// Top of the halt sequencer: depth decoder, state machine, start-up delay
// counter and clock-enable map. All outputs come from registers.
module halt_ctrl
    import halt_ctrl_pkg::*;
#(
    parameter int         SHORT_CYC = 256,
    parameter int         LONG_CYC  = 512,
    parameter logic [1:0] QUAL_SEL  = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_strobe,
    input  logic       lt_tb_ie,
    input  logic       at_ovf_ie,
    input  logic [1:0] at_clk_sel,
    input  logic       wdg_active,
    input  logic       wdg_halt_rst,
    input  logic       lt_irq,
    input  logic       at_irq,
    input  logic       ext_irq,
    input  logic       rst_wake,
    input  logic       boot_long,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       lt_clk_en,
    output logic       at_clk_en,
    output logic       imask_clr,
    output logic       irq_resume,
    output logic [1:0] wake_vec,
    output logic       rst_fetch,
    output logic       wdg_rst_req,
    output logic [3:0] pstate
);
    logic       active_sel, lite_sel, pend_wake, boot_done, lite_q;
    logic [1:0] pend_vec;
    logic [1:0] tmr_en;
    pstate_t    state;

    halt_depth_dec #(.QUAL_SEL(QUAL_SEL)) u_dec (
        .tb_ie(lt_tb_ie), .ovf_ie(at_ovf_ie), .clk_sel(at_clk_sel),
        .lt_irq(lt_irq), .at_irq(at_irq), .ext_irq(ext_irq),
        .active_sel(active_sel), .lite_sel(lite_sel),
        .pend_wake(pend_wake), .pend_vec(pend_vec)
    );

    halt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe),
        .wdg_active(wdg_active), .wdg_halt_rst(wdg_halt_rst),
        .lt_irq(lt_irq), .at_irq(at_irq), .ext_irq(ext_irq),
        .rst_wake(rst_wake), .active_sel(active_sel), .lite_sel(lite_sel),
        .pend_wake(pend_wake), .pend_vec(pend_vec), .boot_done(boot_done),
        .state(state), .lite_q(lite_q), .imask_clr(imask_clr),
        .irq_resume(irq_resume), .wake_vec(wake_vec),
        .rst_fetch(rst_fetch), .wdg_rst_req(wdg_rst_req)
    );

    boot_delay_ctr #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(rst_wake), .long_sel(boot_long),
        .in_boot(state == PS_BOOT), .done(boot_done)
    );

    clk_en_map #(.N_TMR(2)) u_cen (
        .state(state), .lite_q(lite_q), .osc_en(osc_en),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .tmr_clk_en(tmr_en)
    );

    assign lt_clk_en = tmr_en[0];
    assign at_clk_en = tmr_en[1];
    assign pstate    = state;
endmodule

// File: tb/halt_ctrl_tb.sv
module halt_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n, halt_strobe, lt_tb_ie, at_ovf_ie, wdg_active, wdg_halt_rst;
    logic lt_irq, at_irq, ext_irq, rst_wake, boot_long;
    logic [1:0] at_clk_sel;
    logic osc_en, cpu_clk_en, periph_clk_en, lt_clk_en, at_clk_en;
    logic imask_clr, irq_resume, rst_fetch, wdg_rst_req;
    logic [1:0] wake_vec;
    logic [3:0] pstate;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur = "R11";

    always #5 clk = ~clk;

    halt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe),
        .lt_tb_ie(lt_tb_ie), .at_ovf_ie(at_ovf_ie), .at_clk_sel(at_clk_sel),
        .wdg_active(wdg_active), .wdg_halt_rst(wdg_halt_rst),
        .lt_irq(lt_irq), .at_irq(at_irq), .ext_irq(ext_irq),
        .rst_wake(rst_wake), .boot_long(boot_long),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .lt_clk_en(lt_clk_en), .at_clk_en(at_clk_en), .imask_clr(imask_clr),
        .irq_resume(irq_resume), .wake_vec(wake_vec), .rst_fetch(rst_fetch),
        .wdg_rst_req(wdg_rst_req), .pstate(pstate)
    );

    // Behavioural reference: state as integer 0 run, 1 halt, 2 active, 3 boot.
    int m_st = 0;
    int m_left = 0;
    bit m_lite = 1'b1;
    bit m_imask, m_res, m_fetch, m_wdg;
    int m_vec = 0;

    always @(posedge clk) begin
        m_imask = 0; m_res = 0; m_fetch = 0; m_wdg = 0; m_vec = 0;
        if (!rst_n) begin
            m_st = 0; m_lite = 1'b1;
        end else if (rst_wake) begin
            m_st = 3; m_left = boot_long ? 512 : 256;
        end else if (m_st == 0 && halt_strobe) begin
            if (wdg_active && wdg_halt_rst) m_wdg = 1;
            else begin
                bit act;
                bit pend;
                act = lt_tb_ie || (at_ovf_ie && at_clk_sel == 2'b01);
                pend = act ? (lt_tb_ie ? lt_irq : at_irq) : ext_irq;
                m_imask = 1;
                if (pend) begin
                    m_res = 1; m_vec = act ? (lt_tb_ie ? 1 : 2) : 0;
                end else begin
                    m_st = act ? 2 : 1; m_lite = lt_tb_ie;
                end
            end
        end else if (m_st == 1 && ext_irq) begin
            m_st = 0; m_res = 1; m_vec = 0;
        end else if (m_st == 2 && (m_lite ? lt_irq : at_irq)) begin
            m_st = 0; m_res = 1; m_vec = m_lite ? 1 : 2;
        end else if (m_st == 3) begin
            m_left--;
            if (m_left == 0) begin m_st = 0; m_fetch = 1; end
        end
    end

    function automatic logic [14:0] model_vec();
        logic [3:0] ps;
        logic o, c, lt, at;
        ps = 4'b0001 << m_st;
        o  = (m_st != 1);
        c  = (m_st == 0);
        lt = (m_st == 0) || (m_st == 2 && m_lite);
        at = (m_st == 0) || (m_st == 2 && !m_lite);
        return {ps, o, c, c, lt, at, m_imask, m_res, 2'(m_vec), m_fetch, m_wdg};
    endfunction

    // Compare every output with the reference shortly after each edge.
    always @(posedge clk) begin
        #3;
        if (rst_n === 1'b1 || cyc > 2) begin
            logic [14:0] act_v;
            logic [14:0] exp_v;
            act_v = {pstate, osc_en, cpu_clk_en, periph_clk_en, lt_clk_en, at_clk_en,
                     imask_clr, irq_resume, wake_vec, rst_fetch, wdg_rst_req};
            exp_v = model_vec();
            total++;
            if (act_v !== exp_v) begin
                bad++;
                $display("FAIL %s cycle %0d: outputs actual=%h expected=%h", cur, cyc, act_v, exp_v);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act_i, input int exp_i);
        total++;
        if (act_i != exp_i) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_i, exp_i);
        end
    endtask

    task automatic pulse_halt();
        halt_strobe = 1; tick(1); halt_strobe = 0;
    endtask

    initial begin
        int n;
        rst_n = 0; halt_strobe = 0; lt_tb_ie = 0; at_ovf_ie = 0; at_clk_sel = 2'b00;
        wdg_active = 0; wdg_halt_rst = 0; lt_irq = 0; at_irq = 0; ext_irq = 0;
        rst_wake = 0; boot_long = 0;
        tick(3); rst_n = 1; tick(1);
        chk("R11 reset state", pstate, 1);
        chk("R11 reset pulses", {imask_clr, irq_resume, rst_fetch, wdg_rst_req}, 0);

        // Active halt through the time-base enable, lite timer wake.
        cur = "R1"; lt_tb_ie = 1; pulse_halt();
        chk("R2 imask pulse", imask_clr, 1);
        chk("R1 active via time-base", pstate, 4);
        tick(2);
        chk("R4 active enables", {osc_en, cpu_clk_en, periph_clk_en, lt_clk_en, at_clk_en}, 5'b10010);
        cur = "R6"; lt_irq = 1; tick(1); lt_irq = 0;
        chk("R6 resume", {pstate, irq_resume}, {4'b0001, 1'b1});
        chk("R6 vector lite", wake_vec, 1);

        // Active halt through overflow enable plus qualifying clock.
        cur = "R5"; lt_tb_ie = 0; at_ovf_ie = 1; at_clk_sel = 2'b01; pulse_halt();
        chk("R1 active via overflow", pstate, 4);
        chk("R4 auto-reload enable", {lt_clk_en, at_clk_en}, 2'b01);
        ext_irq = 1; tick(1); ext_irq = 0;
        lt_irq = 1; tick(1); lt_irq = 0; tick(1);
        chk("R5 ignored sources", pstate, 4);
        cur = "R12"; pulse_halt(); tick(1);
        chk("R12 strobe in active halt", pstate, 4);
        cur = "R6"; at_irq = 1; tick(1); at_irq = 0;
        chk("R6 vector auto-reload", {pstate, wake_vec}, {4'b0001, 2'd2});

        // Non-qualifying clock: full halt.
        cur = "R7"; at_clk_sel = 2'b10; pulse_halt();
        chk("R1 full halt", pstate, 2);
        chk("R4 full halt enables", {osc_en, cpu_clk_en, periph_clk_en, lt_clk_en, at_clk_en}, 0);
        lt_irq = 1; at_irq = 1; tick(2); lt_irq = 0; at_irq = 0; tick(1);
        chk("R7 timers ignored", pstate, 2);
        ext_irq = 1; tick(1); ext_irq = 0;
        chk("R7 external wake", {pstate, irq_resume, wake_vec}, {4'b0001, 1'b1, 2'd0});

        // Pending wake at strobe.
        cur = "R3"; at_ovf_ie = 0; lt_tb_ie = 1; lt_irq = 1; pulse_halt(); lt_irq = 0;
        chk("R3 instant wake", {pstate, imask_clr, irq_resume}, {4'b0001, 1'b1, 1'b1});
        tick(2);

        // Reset wake from active halt, short delay, with competing timer irq.
        cur = "R9"; pulse_halt(); boot_long = 0;
        rst_wake = 1; lt_irq = 1; tick(1); rst_wake = 0; lt_irq = 0;
        chk("R9 reset beats timer", pstate, 8);
        chk("R4 boot enables", {osc_en, cpu_clk_en, periph_clk_en, lt_clk_en, at_clk_en}, 5'b10000);
        cur = "R8"; n = 0;
        while (pstate == 4'b1000 && n < 2000) begin n++; tick(1); end
        chk("R8 short delay length", n, 256);
        chk("R8 fetch pulse", {pstate, rst_fetch}, {4'b0001, 1'b1});

        // Reset wake from full halt, long delay.
        lt_tb_ie = 0; pulse_halt(); boot_long = 1;
        rst_wake = 1; tick(1); rst_wake = 0; boot_long = 0; n = 0;
        while (pstate == 4'b1000 && n < 2000) begin n++; tick(1); end
        chk("R8 long delay length", n, 512);

        // Reset wake racing a halt strobe in RUN; restart inside boot.
        cur = "R9"; tick(2); halt_strobe = 1; rst_wake = 1; tick(1); halt_strobe = 0; rst_wake = 0;
        chk("R9 reset beats strobe", {pstate, imask_clr}, {4'b1000, 1'b0});
        tick(100); rst_wake = 1; tick(1); rst_wake = 0; n = 0;
        while (pstate == 4'b1000 && n < 2000) begin n++; tick(1); end
        chk("R9 restart delay", n, 256);

        // Watchdog option.
        cur = "R10"; tick(2); lt_tb_ie = 1; wdg_active = 1; wdg_halt_rst = 1; pulse_halt();
        chk("R10 reset request", {pstate, imask_clr, wdg_rst_req}, {4'b0001, 1'b0, 1'b1});
        wdg_halt_rst = 0; tick(1); pulse_halt();
        chk("R10 halt allowed", {pstate, wdg_rst_req}, {4'b0100, 1'b0});

        // Synchronous reset from active halt.
        cur = "R11"; rst_n = 0; tick(1); rst_n = 1;
        chk("R11 reset from active", pstate, 1);
        tick(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule